// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and keeps exceptions precise. Every instruction carries a small record (valid, its PC, whether it is a branch, and a cause code) that moves from stage to stage with it. The fault detectors of each stage raise plain flags. The record keeps only the first cause it picks up, so a fault found early is never replaced by a later one.

The commit point is the end of the memory stage. When the record in the memory stage holds a cause, the controller raises `trap` for that cycle. It blocks the memory-stage write of the faulting instruction and flushes every younger record. It latches the faulting PC and the cause code, and sends fetch to a fixed handler vector. The older instruction in write-back completes as normal. If the faulting instruction sits in the delay slot of a branch, the branch PC is also kept. A return-from-exception request then restarts fetch at the branch, so that the branch runs again.

The controller also owns the fetch PC. Without a redirect it steps by four bytes each cycle, and it loads a resolved branch target when the datapath asks.

Top module: `exc_commit_ctrl`

## Requirements
- R1: Reset state. While and after reset: `fetch_pc` = RESET_PC (default 0), `trap`, `mem_wr_en` and `wb_wr_en` are low, and `epc` and `cause` are 0.
- R2: Fetch PC stepping. With no trap, no return and no redirect, `fetch_pc` grows by 4 each cycle. When `br_redirect` is high, the next `fetch_pc` is `br_target`.
- R3: Cause codes. Codes 1, 2 and 3 come from `if_fault` values 1, 2 and 3 (page fault, misalignment, protection). Code 4 comes from `id_illegal`. Code 5 comes from `ex_ovf`. Codes 6, 7 and 8 come from `mem_fault` values 1, 2 and 3. Code 0 means no cause. Each flag applies to the instruction in that stage during the same cycle.
- R4: When one instruction picks up flags in several stages, the cause latched is the one from the earliest stage.
- R5: `trap` is high in the cycle the faulting instruction sits in the memory stage, which is three cycles after its fetch cycle. A memory-stage fault beats any fault flagged in the same cycle for a younger instruction.
- R6: When `ovf_en` is low, `ex_ovf` is ignored and the instruction completes with both write enables high.
- R7: In the trap cycle `mem_wr_en` is low. On the next cycle every younger record is invalid, and `wb_wr_en` is low for the faulting instruction. An older instruction in write-back during the trap cycle keeps `wb_wr_en` high.
- R8: After a trap, `fetch_pc` = TRAP_VEC (default 0x80), `epc` holds the PC of the faulting instruction and `cause` holds its code. Both stay unchanged until the next trap.
- R9: If the instruction in write-back during the trap cycle is a branch (`if_branch` was high when it was fetched), `in_dslot` is set and `bpc` holds that branch's PC. Otherwise `in_dslot` is cleared.
- R10: When `eret` is high and `trap` is low, the next `fetch_pc` is `bpc` if `in_dslot` is set and `epc` if it is not. When `trap` and `eret` are high together, the trap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch stage holds a real instruction |
| if_branch | input | 1 | Fetched instruction is a branch with one delay slot |
| if_fault | input | 2 | Fetch fault: 0 none, 1 page, 2 misaligned, 3 protection |
| id_illegal | input | 1 | Decode found an undefined opcode |
| ex_ovf | input | 1 | Execute arithmetic overflow |
| mem_fault | input | 2 | Memory fault: 0 none, 1 page, 2 misaligned, 3 protection |
| ovf_en | input | 1 | Enable for the maskable overflow cause |
| br_redirect | input | 1 | Load branch target into fetch PC |
| br_target | input | 32 | Resolved branch target |
| eret | input | 1 | Return from exception |
| fetch_pc | output | 32 | PC of the instruction being fetched |
| trap | output | 1 | Exception taken this cycle |
| mem_wr_en | output | 1 | Memory-stage write allowed |
| wb_wr_en | output | 1 | Write-back register write allowed |
| epc | output | 32 | Saved faulting PC |
| bpc | output | 32 | Saved branch PC for the delay-slot case |
| cause | output | 4 | Saved cause code |
| in_dslot | output | 1 | Saved fault was in a delay slot |

## Verification
Two cases can happen in the same cycle. The first is a memory-stage fault of an older instruction together with a fault flag for a younger instruction in an earlier stage. The bench sets up a table row in which the first instruction faults in the memory stage while the second raises overflow in execute on that same edge. It passes only if the latched cause and PC belong to the older instruction and the younger one is flushed. The second case is a trap together with a return request. The bench raises `eret` in the trap cycle and expects the handler vector, not the saved PC, on the next fetch.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PC_W = 32;

  typedef enum logic [3:0] {
    CS_NONE      = 4'd0,
    CS_IF_PAGE   = 4'd1,
    CS_IF_ALIGN  = 4'd2,
    CS_IF_PROT   = 4'd3,
    CS_ILLEGAL   = 4'd4,
    CS_OVF       = 4'd5,
    CS_MEM_PAGE  = 4'd6,
    CS_MEM_ALIGN = 4'd7,
    CS_MEM_PROT  = 4'd8
  } cause_e;

  typedef struct packed {
    logic             vld;
    logic             brn;
    cause_e           cause;
    logic [PC_W-1:0]  pc;
  } rec_t;
endpackage

// File: rtl/exc_cause_merge.sv
module exc_cause_merge
  import exc_pkg::*;
(
  input  rec_t   rec_i,
  input  cause_e det_i,
  output rec_t   rec_o
);
  // The first cause an instruction picks up is kept (R4)
  always_comb begin
    rec_o = rec_i;
    if (rec_i.vld && (rec_i.cause == CS_NONE)) begin
      rec_o.cause = det_i;
    end
  end
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  rec_t d_i,
  output rec_t q_o
);
  rec_t nxt;

  always_comb begin
    nxt = d_i;
    if (flush_i) begin
      nxt.vld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  rec_t            mem_rec_i,
  input  rec_t            wb_rec_i,
  output logic            trap_o,
  output logic [PC_W-1:0] epc_o,
  output logic [PC_W-1:0] bpc_o,
  output cause_e          cause_o,
  output logic            dslot_o
);
  logic [PC_W-1:0] epc_n, bpc_n;
  cause_e          cause_n;
  logic            dslot_n;

  assign trap_o = mem_rec_i.vld && (mem_rec_i.cause != CS_NONE);

  always_comb begin
    epc_n   = epc_o;
    bpc_n   = bpc_o;
    cause_n = cause_o;
    dslot_n = dslot_o;
    if (trap_o) begin
      epc_n   = mem_rec_i.pc;
      cause_n = mem_rec_i.cause;
      dslot_n = wb_rec_i.vld && wb_rec_i.brn;
      bpc_n   = wb_rec_i.pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o   <= '0;
      bpc_o   <= '0;
      cause_o <= CS_NONE;
      dslot_o <= 1'b0;
    end else begin
      epc_o   <= epc_n;
      bpc_o   <= bpc_n;
      cause_o <= cause_n;
      dslot_o <= dslot_n;
    end
  end

  AST_CAUSE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (cause_o != CS_NONE)); // R8
  AST_SAVED_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |=> ($stable(epc_o) && $stable(cause_o) && $stable(dslot_o))); // R8
endmodule

// File: rtl/exc_pc_unit.sv
module exc_pc_unit
  import exc_pkg::*;
#(
  parameter logic [PC_W-1:0] TRAP_VEC    = 32'h80,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter int              INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic            eret_i,
  input  logic [PC_W-1:0] ret_pc_i,
  input  logic            br_i,
  input  logic [PC_W-1:0] br_target_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);
  logic [PC_W-1:0] pc_n;

  always_comb begin
    if (trap_i)      pc_n = TRAP_VEC;
    else if (eret_i) pc_n = ret_pc_i;
    else if (br_i)   pc_n = br_target_i;
    else             pc_n = pc_o + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_o <= RESET_PC;
    else        pc_o <= pc_n;
  end

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (pc_o == TRAP_VEC)); // R8
  AST_RETURN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !trap_i) |=> (pc_o == $past(ret_pc_i))); // R10
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h80,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic            if_branch,
  input  logic [1:0]      if_fault,
  input  logic            id_illegal,
  input  logic            ex_ovf,
  input  logic [1:0]      mem_fault,
  input  logic            ovf_en,
  input  logic            br_redirect,
  input  logic [PC_W-1:0] br_target,
  input  logic            eret,
  output logic [PC_W-1:0] fetch_pc,
  output logic            trap,
  output logic            mem_wr_en,
  output logic            wb_wr_en,
  output logic [PC_W-1:0] epc,
  output logic [PC_W-1:0] bpc,
  output logic [3:0]      cause,
  output logic            in_dslot
);
  localparam int N_FLT  = 4;          // stages able to fault: IF, ID, EX, MEM
  localparam int MEM_IX = N_FLT - 1;

  cause_e          det [N_FLT];
  rec_t            raw [N_FLT];
  rec_t            cur [N_FLT];
  rec_t            stg [1:N_FLT];     // ID, EX, MEM, WB records
  rec_t            if_rec;
  cause_e          cause_q;
  logic [PC_W-1:0] ret_pc;

  assign if_rec = '{vld: if_valid, brn: if_branch, cause: CS_NONE, pc: fetch_pc};

  always_comb begin
    unique case (if_fault)
      2'd1:    det[0] = CS_IF_PAGE;
      2'd2:    det[0] = CS_IF_ALIGN;
      2'd3:    det[0] = CS_IF_PROT;
      default: det[0] = CS_NONE;
    endcase
    det[1] = id_illegal ? CS_ILLEGAL : CS_NONE;
    det[2] = (ex_ovf && ovf_en) ? CS_OVF : CS_NONE;
    unique case (mem_fault)
      2'd1:    det[3] = CS_MEM_PAGE;
      2'd2:    det[3] = CS_MEM_ALIGN;
      2'd3:    det[3] = CS_MEM_PROT;
      default: det[3] = CS_NONE;
    endcase
  end

  for (genvar k = 0; k < N_FLT; k++) begin : g_merge
    if (k == 0) begin : g_src_if
      assign raw[k] = if_rec;
    end else begin : g_src_reg
      assign raw[k] = stg[k];
    end
    exc_cause_merge u_merge (.rec_i(raw[k]), .det_i(det[k]), .rec_o(cur[k]));
  end

  for (genvar k = 1; k <= N_FLT; k++) begin : g_stage
    exc_stage_reg u_reg (
      .clk(clk), .rst_n(rst_n), .flush_i(trap), .d_i(cur[k-1]), .q_o(stg[k])
    );
  end

  exc_commit u_commit (
    .clk(clk), .rst_n(rst_n), .mem_rec_i(cur[MEM_IX]), .wb_rec_i(stg[N_FLT]),
    .trap_o(trap), .epc_o(epc), .bpc_o(bpc), .cause_o(cause_q), .dslot_o(in_dslot)
  );

  assign ret_pc = in_dslot ? bpc : epc;

  exc_pc_unit #(.TRAP_VEC(TRAP_VEC), .RESET_PC(RESET_PC), .INSTR_BYTES(4)) u_pc (
    .clk(clk), .rst_n(rst_n), .trap_i(trap), .eret_i(eret), .ret_pc_i(ret_pc),
    .br_i(br_redirect), .br_target_i(br_target), .pc_o(fetch_pc)
  );

  assign cause     = cause_q;
  assign mem_wr_en = cur[MEM_IX].vld && !trap;
  assign wb_wr_en  = stg[N_FLT].vld;

  AST_YOUNGER_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (!stg[1].vld && !stg[2].vld && !stg[3].vld && !wb_wr_en)); // R7
endmodule

// File: tb/exc_commit_ctrl_tb.sv
module exc_commit_ctrl_tb;
  localparam logic [31:0] VEC = 32'h80;

  typedef struct packed {
    logic [3:0] as;    // stage of first instr fault (15 = none)
    logic [3:0] asub;
    logic [3:0] bs;    // stage of second instr fault
    logic [3:0] bsub;
    logic       en;
    logic [3:0] ecause;
    logic       eidx;  // which instr is expected to fault
    logic [3:0] ecyc;  // trap cycle, 0 = none
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{4'd0, 4'd1, 4'd15, 4'd0, 1'b1, 4'd1, 1'b0, 4'd3},
    '{4'd1, 4'd0, 4'd15, 4'd0, 1'b1, 4'd4, 1'b0, 4'd3},
    '{4'd2, 4'd0, 4'd15, 4'd0, 1'b1, 4'd5, 1'b0, 4'd3},
    '{4'd2, 4'd0, 4'd15, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0},
    '{4'd3, 4'd3, 4'd15, 4'd0, 1'b1, 4'd8, 1'b0, 4'd3},
    '{4'd3, 4'd1, 4'd2,  4'd0, 1'b1, 4'd6, 1'b0, 4'd3},
    '{4'd15,4'd0, 4'd1,  4'd0, 1'b1, 4'd4, 1'b1, 4'd4},
    '{4'd2, 4'd0, 4'd3,  4'd1, 1'b0, 4'd6, 1'b1, 4'd4},
    '{4'd1, 4'd0, 4'd0,  4'd1, 1'b1, 4'd4, 1'b0, 4'd3},
    '{4'd15,4'd0, 4'd0,  4'd3, 1'b1, 4'd3, 1'b1, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        if_valid, if_branch, id_illegal, ex_ovf, ovf_en, br_redirect, eret;
  logic [1:0]  if_fault, mem_fault;
  logic [31:0] br_target, fetch_pc, epc, bpc;
  logic        trap, mem_wr_en, wb_wr_en, in_dslot;
  logic [3:0]  cause;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  exc_commit_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_branch(if_branch),
    .if_fault(if_fault), .id_illegal(id_illegal), .ex_ovf(ex_ovf),
    .mem_fault(mem_fault), .ovf_en(ovf_en), .br_redirect(br_redirect),
    .br_target(br_target), .eret(eret), .fetch_pc(fetch_pc), .trap(trap),
    .mem_wr_en(mem_wr_en), .wb_wr_en(wb_wr_en), .epc(epc), .bpc(bpc),
    .cause(cause), .in_dslot(in_dslot)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_in();
    if_valid = 1'b1; if_branch = 1'b0; if_fault = 2'd0; id_illegal = 1'b0;
    ex_ovf = 1'b0; mem_fault = 2'd0; br_redirect = 1'b0; br_target = '0; eret = 1'b0;
  endtask

  task automatic do_reset();
    clr_in();
    ovf_en = 1'b1;
    rst_n  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_flag(input int stg, input logic [3:0] sub, input int now);
    if (stg == now) begin
      case (stg)
        0: if_fault   = sub[1:0];
        1: id_illegal = 1'b1;
        2: ex_ovf     = 1'b1;
        3: mem_fault  = sub[1:0];
        default: ;
      endcase
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    #1;
    chk("R1 fetch_pc", fetch_pc, 32'h0);
    chk("R1 trap", {31'b0, trap}, 32'd0);
    chk("R1 mem_wr_en", {31'b0, mem_wr_en}, 32'd0);
    chk("R1 wb_wr_en", {31'b0, wb_wr_en}, 32'd0);
    chk("R1 epc", epc, 32'h0);
    chk("R1 cause", {28'b0, cause}, 32'd0);

    // Table walk: two instructions at PC 0 and 4, faults by stage
    for (int r = 0; r < 10; r++) begin
      do_reset();
      for (int c = 0; c < 6; c++) begin
        clr_in();
        ovf_en = TBL[r].en;
        put_flag(int'(TBL[r].as), TBL[r].asub, c);
        put_flag(int'(TBL[r].bs), TBL[r].bsub, c - 1);
        #1;
        chk("R5 trap timing", {31'b0, trap},
            {31'b0, (TBL[r].ecyc != 0) && (c == int'(TBL[r].ecyc))});
        if (TBL[r].ecyc == 0 || c <= int'(TBL[r].ecyc))
          chk("R2 sequential pc", fetch_pc, 32'(4 * c));
        if (TBL[r].ecyc != 0 && c == int'(TBL[r].ecyc)) begin
          chk("R7 mem write blocked", {31'b0, mem_wr_en}, 32'd0);
          chk("R7 older instr writes back", {31'b0, wb_wr_en}, {31'b0, c == 4});
        end
        if (TBL[r].ecyc != 0 && c == int'(TBL[r].ecyc) + 1) begin
          chk("R8 vector", fetch_pc, VEC);
          chk("R3 cause code", {28'b0, cause}, {28'b0, TBL[r].ecause});
          chk("R8 epc", epc, TBL[r].eidx ? 32'd4 : 32'd0);
          chk("R7 faulting instr no writeback", {31'b0, wb_wr_en}, 32'd0);
        end
        if (TBL[r].ecyc == 0) begin
          if (c == 3) chk("R6 masked ovf mem write", {31'b0, mem_wr_en}, 32'd1);
          if (c == 4) chk("R6 masked ovf writeback", {31'b0, wb_wr_en}, 32'd1);
          if (c == 5) chk("R6 no cause", {28'b0, cause}, 32'd0);
        end
        @(negedge clk);
      end
    end

    // R4: same instruction flagged in every stage, fetch cause wins
    do_reset();
    for (int c = 0; c < 5; c++) begin
      clr_in();
      if (c == 0) if_fault = 2'd2;
      if (c == 1) id_illegal = 1'b1;
      if (c == 2) ex_ovf = 1'b1;
      if (c == 3) mem_fault = 2'd1;
      #1;
      if (c == 3) chk("R5 trap with many flags", {31'b0, trap}, 32'd1);
      if (c == 4) chk("R4 earliest cause", {28'b0, cause}, 32'd2);
      @(negedge clk);
    end

    // R9 and R10: fault in delay slot, return to branch
    do_reset();
    for (int c = 0; c < 7; c++) begin
      clr_in();
      if (c == 0) if_branch = 1'b1;
      if (c == 2) id_illegal = 1'b1;
      if (c == 5) eret = 1'b1;
      #1;
      if (c == 4) chk("R5 delay slot trap", {31'b0, trap}, 32'd1);
      if (c == 5) begin
        chk("R9 in_dslot", {31'b0, in_dslot}, 32'd1);
        chk("R9 bpc", bpc, 32'h0);
        chk("R9 epc", epc, 32'h4);
      end
      if (c == 6) chk("R10 return to branch", fetch_pc, 32'h0);
      @(negedge clk);
    end

    // R10: return without delay slot goes to epc
    do_reset();
    for (int c = 0; c < 7; c++) begin
      clr_in();
      if (c == 2) id_illegal = 1'b1;
      if (c == 5) eret = 1'b1;
      #1;
      if (c == 5) chk("R9 no dslot", {31'b0, in_dslot}, 32'd0);
      if (c == 6) chk("R10 return to epc", fetch_pc, 32'h4);
      @(negedge clk);
    end

    // R10: trap and return in the same cycle, trap wins
    do_reset();
    for (int c = 0; c < 5; c++) begin
      clr_in();
      if (c == 1) id_illegal = 1'b1;
      if (c == 3) eret = 1'b1;
      #1;
      if (c == 3) chk("R10 trap with eret", {31'b0, trap}, 32'd1);
      if (c == 4) chk("R10 trap beats eret", fetch_pc, VEC);
      @(negedge clk);
    end

    // R2: branch redirect
    do_reset();
    for (int c = 0; c < 4; c++) begin
      clr_in();
      if (c == 1) begin br_redirect = 1'b1; br_target = 32'h200; end
      #1;
      if (c == 2) chk("R2 redirect target", fetch_pc, 32'h200);
      if (c == 3) chk("R2 step after redirect", fetch_pc, 32'h204);
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule